// File: doc/BRIEF.md
# Montgomery-Domain Modular Inverse Unit

This block returns the modular inverse of a field element that is already held in Montgomery form. The modulus is an arbitrary odd number (a prime in normal use) of up to `DATA_W` bits, and the result is also in Montgomery form. For an operand `x = a*2^W mod p`, the block returns `a^-1 * 2^W mod p`, which is the same as `x^-1 * 2^(2W) mod p`. It is intended to serve an affine-coordinate curve arithmetic datapath, which calls it once per group operation.

The work runs in three phases under a small controller, and all of it uses one shared add/subtract circuit. No multiplier is used at any point.

- **Conversion.** The controller builds the constant `2^(2W) mod p` by repeated modular doubling. This constant seeds one of the coefficients.
- **Calculation.** A binary almost-inverse loop runs on two shrinking values and two coefficients.
  - An even value is halved, and the opposite coefficient is doubled modulo p.
  - When both values are odd, the smaller value is subtracted from the larger one, and the two coefficients are summed modulo p.
  - Each halving step adds one to an iteration count `c`.
- **Halving.** The controller negates the accumulated coefficient modulo p. It then divides it by two modulo p, `c` times. A step that meets an odd value adds p before the shift.

The user pulses `start` with `operand` and `modulus` valid. The unit captures both and works on its own. It raises `done` for one cycle when `result` is ready.

Top module: `minv_unit`

## Requirements
- R1: When `done` pulses, `result * operand mod modulus` equals `2^(2*DATA_W) mod modulus`, for any operand in [1, modulus-1] that is coprime to the modulus.
- R2: Every result delivered with `done` lies in [0, modulus-1].
- R3: A `start` seen on a rising edge while the unit is idle captures `operand` and `modulus` in that cycle. `done` is low in the cycle that follows that edge. `done` is high for exactly one cycle per operation.
- R4: A `start` pulse, or any change on `operand` or `modulus`, while an operation is in progress has no effect on that operation's result.
- R5: `result` keeps its value from the `done` pulse until the next accepted `start`, whatever `operand` and `modulus` do meanwhile.
- R6: An operand of zero is not a supported input and its result is unspecified. `done` still pulses within the R7 bound.
- R7: Counting from the edge that accepts `start`, `done` is high after no more than `14*DATA_W+8` rising edges.
- R8: Any odd modulus from 3 up to `2^DATA_W - 1` is supported, including moduli with the top bit set. The operand corner values 1 and modulus-1 are also covered.
- R9: After reset `done` is low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an inversion; honoured only while idle |
| operand | input | DATA_W | Value to invert, in Montgomery form, below the modulus |
| modulus | input | DATA_W | Odd modulus, at least 3 |
| done | output | 1 | One-cycle pulse when `result` becomes valid |
| result | output | DATA_W | Inverse in Montgomery form |

## Verification
The bench builds the unit with the default width of 81 bits. This lets it drive random odd moduli with the top bit forced, so the borrow and carry out of the top adder bit matter, together with small moduli where the conversion constant wraps on nearly every doubling. Directed cases use the modulus 3, the Mersenne prime `2^61-1`, operands 1 and modulus-1, a zero operand, a stray `start` mid-operation and input changes after completion. The expected product `2^(2W) mod p` comes from a shift-and-subtract reference.

// File: rtl/minv_pkg.sv
package minv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_CALC,
        ST_SUBV,
        ST_ADD,
        ST_RED,
        ST_NEG,
        ST_HALVE
    } minv_state_e;

    typedef enum logic {
        TGT_R,
        TGT_S
    } minv_tgt_e;

endpackage

// File: rtl/minv_addsub.sv
module minv_addsub #(
    parameter int WIDTH = 82
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH:0]   sum_o
);
    logic [WIDTH:0] b_ext;

    always_comb begin
        b_ext = {1'b0, b_i} ^ {(WIDTH+1){sub_i}};
        sum_o = {1'b0, a_i} + b_ext + {{WIDTH{1'b0}}, sub_i};
    end
endmodule

// File: rtl/minv_redsel.sv
module minv_redsel #(
    parameter int WIDTH = 81
) (
    input  logic [WIDTH-1:0] keep_i,
    input  logic [WIDTH-1:0] diff_i,
    input  logic             neg_i,
    output logic [WIDTH-1:0] val_o,
    output logic             zero_o
);
    always_comb begin
        val_o  = neg_i ? keep_i : diff_i;
        zero_o = !neg_i && (diff_i == '0);
    end
endmodule

// File: rtl/minv_unit.sv
module minv_unit
    import minv_pkg::*;
#(
    parameter int DATA_W = 81
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] modulus,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    localparam int W      = DATA_W;
    localparam int CONV_N = 2 * W;
    localparam int CW     = $clog2(2 * W + 1) + 1;

    typedef struct packed {
        minv_state_e   st;
        minv_tgt_e     tgt;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W:0]    w;
        logic [W-1:0]  p;
        logic [W-1:0]  u;
        logic [W-1:0]  v;
        logic [W-1:0]  r;
        logic [W-1:0]  s;
    } regs_t;

    regs_t q, n;

    // shared arithmetic
    logic [W:0]   add_a;
    logic [W:0]   add_b;
    logic         add_sub;
    logic [W+1:0] add_sum;
    logic         add_neg;
    logic [W-1:0] red_val;
    logic         diff_zero;

    minv_addsub #(.WIDTH(W + 1)) u_add (
        .a_i   (add_a),
        .b_i   (add_b),
        .sub_i (add_sub),
        .sum_o (add_sum)
    );

    assign add_neg = add_sum[W+1];

    minv_redsel #(.WIDTH(W)) u_red (
        .keep_i (add_a[W-1:0]),
        .diff_i (add_sum[W-1:0]),
        .neg_i  (add_neg),
        .val_o  (red_val),
        .zero_o (diff_zero)
    );

    // operand steering for the single adder
    always_comb begin
        add_a   = '0;
        add_b   = '0;
        add_sub = 1'b0;
        unique case (q.st)
            ST_CONV: begin
                add_a   = {q.s, 1'b0};
                add_b   = {1'b0, q.p};
                add_sub = 1'b1;
            end
            ST_CALC: begin
                add_sub = 1'b1;
                if (!q.u[0]) begin
                    add_a = {q.s, 1'b0};
                    add_b = {1'b0, q.p};
                end else if (!q.v[0]) begin
                    add_a = {q.r, 1'b0};
                    add_b = {1'b0, q.p};
                end else begin
                    add_a = {1'b0, q.u};
                    add_b = {1'b0, q.v};
                end
            end
            ST_SUBV: begin
                add_a   = {1'b0, q.v};
                add_b   = {1'b0, q.u};
                add_sub = 1'b1;
            end
            ST_ADD: begin
                add_a = {1'b0, q.r};
                add_b = {1'b0, q.s};
            end
            ST_RED: begin
                add_a   = q.w;
                add_b   = {1'b0, q.p};
                add_sub = 1'b1;
            end
            ST_NEG: begin
                add_a   = {1'b0, q.p};
                add_b   = {1'b0, q.r};
                add_sub = 1'b1;
            end
            ST_HALVE: begin
                add_a = {1'b0, q.r};
                add_b = {1'b0, q.p};
            end
            default: ;
        endcase
    end

    // next-state logic
    always_comb begin
        n      = q;
        n.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    n.p   = modulus;
                    n.u   = modulus;
                    n.v   = operand;
                    n.r   = '0;
                    n.s   = {{(W-1){1'b0}}, 1'b1};
                    n.cnt = '0;
                    n.st  = ST_CONV;
                end
            end
            ST_CONV: begin
                n.s   = red_val;
                n.cnt = q.cnt + 1'b1;
                if (q.cnt == CW'(CONV_N - 1)) begin
                    n.cnt = '0;
                    n.st  = ST_CALC;
                end
            end
            ST_CALC: begin
                if (q.v == '0) begin
                    n.st = ST_NEG;
                end else if (!q.u[0]) begin
                    n.u   = q.u >> 1;
                    n.s   = red_val;
                    n.cnt = q.cnt + 1'b1;
                end else if (!q.v[0]) begin
                    n.v   = q.v >> 1;
                    n.r   = red_val;
                    n.cnt = q.cnt + 1'b1;
                end else if (add_neg) begin
                    n.st = ST_SUBV;
                end else if (diff_zero) begin
                    n.v   = '0;
                    n.tgt = TGT_S;
                    n.st  = ST_ADD;
                end else begin
                    n.u   = add_sum[W-1:0];
                    n.tgt = TGT_R;
                    n.st  = ST_ADD;
                end
            end
            ST_SUBV: begin
                n.v   = add_sum[W-1:0];
                n.tgt = TGT_S;
                n.st  = ST_ADD;
            end
            ST_ADD: begin
                n.w  = add_sum[W:0];
                n.st = ST_RED;
            end
            ST_RED: begin
                if (q.tgt == TGT_R) n.r = red_val;
                else                n.s = red_val;
                n.st = ST_CALC;
            end
            ST_NEG: begin
                n.r = (q.r == '0) ? '0 : add_sum[W-1:0];
                if (q.cnt == '0) begin
                    n.st   = ST_IDLE;
                    n.done = 1'b1;
                end else begin
                    n.st = ST_HALVE;
                end
            end
            ST_HALVE: begin
                n.r   = q.r[0] ? add_sum[W:1] : (q.r >> 1);
                n.cnt = q.cnt - 1'b1;
                if (q.cnt == CW'(1)) begin
                    n.st   = ST_IDLE;
                    n.done = 1'b1;
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, tgt: TGT_R, default: '0};
        end else begin
            q <= n;
        end
    end

    assign done   = q.done;
    assign result = q.r;

    // observation points for the bound checker
    minv_state_e  state_w;
    logic [W-1:0] mod_w;
    assign state_w = q.st;
    assign mod_w   = q.p;

endmodule

// File: rtl/minv_unit_chk.sv
module minv_unit_chk
    import minv_pkg::*;
#(
    parameter int DATA_W = 81
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input minv_state_e       state_w,
    input logic [DATA_W-1:0] mod_w
);
    localparam int LAT_MAX = 14 * DATA_W + 8;

    int unsigned busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  busy_cnt <= 0;
        else if (state_w == ST_IDLE) busy_cnt <= 0;
        else                         busy_cnt <= busy_cnt + 1;
    end

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_early_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_IDLE && start) |=> !done);

    assert_result_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result < mod_w));

    assert_busy_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w != ST_IDLE && start) |=> $stable(mod_w));

    assert_result_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_IDLE && !start) |=> $stable(result));

    assert_latency_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= LAT_MAX);

endmodule

bind minv_unit minv_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .result  (result),
    .state_w (state_w),
    .mod_w   (mod_w)
);

// File: tb/minv_unit_tb.sv
`timescale 1ns/1ps
module minv_unit_tb;
    localparam int W       = 81;
    localparam int LAT_MAX = 14 * W + 8;
    localparam int LIMIT   = 20 * W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] operand = '0;
    logic [W-1:0] modulus = '0;
    logic         done;
    logic [W-1:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    minv_unit #(.DATA_W(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .operand (operand),
        .modulus (modulus),
        .done    (done),
        .result  (result)
    );

    function automatic logic [W-1:0] mulmod(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic [W-1:0] p);
        logic [W+1:0] acc = '0;
        for (int i = W - 1; i >= 0; i--) begin
            acc = acc << 1;
            if (acc >= {2'b00, p}) acc = acc - {2'b00, p};
            if (b[i]) begin
                acc = acc + {2'b00, a};
                if (acc >= {2'b00, p}) acc = acc - {2'b00, p};
            end
        end
        return acc[W-1:0];
    endfunction

    function automatic logic [W-1:0] pow2mod(input int e, input logic [W-1:0] p);
        logic [W+1:0] acc = 1;
        for (int i = 0; i < e; i++) begin
            acc = acc << 1;
            if (acc >= {2'b00, p}) acc = acc - {2'b00, p};
        end
        return acc[W-1:0];
    endfunction

    function automatic logic [W-1:0] gcd(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] t;
        while (b != '0) begin
            t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    function automatic logic [W-1:0] rand_w();
        logic [95:0] t = {$urandom, $urandom, $urandom};
        return t[W-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one inversion; disturb != 0 injects a stray start and changed inputs mid-run
    task automatic run(input logic [W-1:0] x, input logic [W-1:0] p, input bit disturb,
                       input bit zero_case);
        int lat;
        logic [W-1:0] held;
        logic [W-1:0] want;
        @(negedge clk);
        operand = x;
        modulus = p;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat   = 1;
        // R3: no done right after the accepting edge
        chk(done == 1'b0, "R3 early done", {{(W-1){1'b0}}, done}, '0);
        while (!done && lat < LIMIT) begin
            if (disturb && lat == 5) begin
                operand = rand_w();
                modulus = rand_w() | 1;
                start   = 1'b1;
            end
            if (disturb && lat == 6) start = 1'b0;
            @(negedge clk);
            lat++;
        end
        // R7 / R6: completion within bound
        chk(done && lat <= LAT_MAX, zero_case ? "R6 zero operand completes" : "R7 latency",
            W'(lat), W'(LAT_MAX));
        if (!done) return;
        if (!zero_case) begin
            want = pow2mod(2 * W, p);
            chk(result < p, "R2 range", result, p);
            chk(mulmod(result, x, p) == want, disturb ? "R4 busy start ignored" : "R1 product",
                mulmod(result, x, p), want);
        end
        held = result;
        operand = rand_w();
        modulus = rand_w();
        @(negedge clk);
        // R3: one-cycle pulse
        chk(done == 1'b0, "R3 pulse width", {{(W-1){1'b0}}, done}, '0);
        repeat (3) begin
            operand = rand_w();
            @(negedge clk);
        end
        // R5: held while idle
        chk(result == held, "R5 result held", result, held);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] p;
        logic [W-1:0] x;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(done == 1'b0, "R9 reset done", {{(W-1){1'b0}}, done}, '0);
        chk(result == '0, "R9 reset result", result, '0);
        rst_n = 1'b1;

        // R8 corner moduli and operands
        run(1, 3, 1'b0, 1'b0);
        run(2, 3, 1'b0, 1'b0);
        p = (W'(1) << 61) - 1;
        run(1, p, 1'b0, 1'b0);
        run(p - 1, p, 1'b0, 1'b0);
        p = {W{1'b1}};
        run(p - 1, p, 1'b0, 1'b0);
        run(1, p, 1'b0, 1'b0);
        // R6 zero operand
        run('0, 7, 1'b0, 1'b1);
        // R4 disturbed runs
        run(12345, (W'(1) << 61) - 1, 1'b1, 1'b0);

        for (int i = 0; i < 40; i++) begin
            p = rand_w() | 1 | (W'(1) << (W - 1));
            do x = rand_w() % p; while (x == '0 || gcd(p, x) != 1);
            run(x, p, (i % 8) == 3, 1'b0);
        end
        for (int i = 0; i < 20; i++) begin
            p = (rand_w() >> ($urandom % (W - 3))) | 3;
            do x = rand_w() % p; while (x == '0 || gcd(p, x) != 1);
            run(x, p, 1'b0, 1'b0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule